// File: doc/BRIEF.md
# Keyboard Command Responder Queue

This block sits beside one serial channel and plays the keyboard end of the link. It holds a circular byte queue of keyboard reports that the host drains through the channel's data port. A key event (a 7-bit key code plus a release flag) is translated through a 128-entry parameter table into a report byte and queued. A command byte sent by the host on the channel's transmit path is decoded, and two of the command codes are answered by queuing a fixed two-byte reply. Every read of the data port pops one byte, and a one-cycle receive strobe tells the channel that a byte is waiting: after each accepted push, and again after each pop that leaves bytes behind.

The push side is steered by a two-state machine. In `ST_IDLE` a reply and a key event can both be accepted in one cycle. The store takes two writes per cycle, so both reply bytes go in together. If a key event arrives in the same cycle as a reply, it is parked in a hold register, and the transition `IDLE_TO_HOLD` is taken. In `ST_HOLD` the parked byte is queued, together with any new key event, and the transition `HOLD_TO_IDLE` is always taken on the next edge. All other cycles stay in `ST_IDLE` (`IDLE_STAY`).

Top module: `kbd_reply_queue`

## Requirements
- R1: After reset the queue is empty: `has_data` is 0, `rx_strobe` is 0 and `pop_data` reads 0x00.
- R2: A key event with code c and release flag r queues the byte XLATE[c] OR (r << 7). The default table maps c to (37*c + 11) mod 128.
- R3: Bytes leave in the order they were queued. `pop_data` shows the oldest byte combinationally in the same cycle that `pop` is high, and that byte is removed at the clock edge.
- R4: A pop while the queue is empty returns 0x00 and leaves the queue empty.
- R5: The queue holds DEPTH bytes (256 by default). A push while the queue holds DEPTH bytes is dropped. A pop in the same cycle does not make room for it.
- R6: `rx_strobe` is high for the one cycle after any clock edge at which a byte was accepted.
- R7: `rx_strobe` is high after a pop that leaves at least one byte in the queue. It stays low after a pop that empties the queue when no push comes with it.
- R8: Command byte 0x01 queues 0xFF and then 0x05.
- R9: Command byte 0x07 queues 0xFE and then 0x20. Any other command byte queues nothing.
- R10: When a reply command and a key event arrive in the same cycle in `ST_IDLE`, both reply bytes are queued first and the key byte directly after them, one cycle later (`ST_HOLD`).
- R11: In `ST_HOLD` a command byte is ignored. A key event that arrives in that cycle is queued right after the held key byte. The state returns to `ST_IDLE` on the next edge.
- R12: A single push and a pop of a non-empty, non-full queue in the same cycle are both honoured, and the byte count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Key code, used as an index into the translation table |
| key_release | input | 1 | 1 for a key release, 0 for a key press |
| cmd_valid | input | 1 | Host command byte strobe from the transmit path |
| cmd_byte | input | 8 | Host command byte |
| pop | input | 1 | Data-port read strobe |
| pop_data | output | 8 | Oldest queued byte, or 0x00 when empty |
| has_data | output | 1 | Queue not empty |
| rx_strobe | output | 1 | One-cycle receive-available signal to the channel |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a reply command and a key event. The bench raises both strobes together, then drives a second command and key during the hold cycle. It judges the result by popping the whole sequence and checking its order and length. The second pair is a push and a pop. The bench drives both in one cycle, first on a queue holding one byte and then on a full queue. It judges them by the byte returned in that cycle, by the `has_data` level afterwards, and by the full count of bytes drained.

// File: rtl/kq_pkg.sv
package kq_pkg;

    typedef logic [7:0] xlate_t [128];

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } kq_state_e;

    localparam logic [7:0] CMD_RESET  = 8'h01;
    localparam logic [7:0] CMD_LAYOUT = 8'h07;
    localparam logic [7:0] RST_ACK0   = 8'hFF;
    localparam logic [7:0] RST_ACK1   = 8'h05;
    localparam logic [7:0] LAY_ACK0   = 8'hFE;
    localparam logic [7:0] LAY_ACK1   = 8'h20;

    function automatic xlate_t default_xlate();
        xlate_t t;
        for (int i = 0; i < 128; i++) begin
            t[i] = 8'((i * 37 + 11) % 128);
        end
        return t;
    endfunction

endpackage

// File: rtl/kq_cmd_decode.sv
module kq_cmd_decode (
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       reply_hit,
    output logic [7:0] reply_b0,
    output logic [7:0] reply_b1
);
    import kq_pkg::*;

    always_comb begin
        reply_hit = 1'b0;
        reply_b0  = 8'h00;
        reply_b1  = 8'h00;
        if (cmd_valid) begin
            unique case (cmd_byte)
                CMD_RESET: begin
                    reply_hit = 1'b1;
                    reply_b0  = RST_ACK0;
                    reply_b1  = RST_ACK1;
                end
                CMD_LAYOUT: begin
                    reply_hit = 1'b1;
                    reply_b0  = LAY_ACK0;
                    reply_b1  = LAY_ACK1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/kq_key_xlate.sv
module kq_key_xlate #(
    parameter kq_pkg::xlate_t XLATE = kq_pkg::default_xlate()
) (
    input  logic [6:0] code,
    input  logic       release_flag,
    output logic [7:0] report
);
    always_comb begin
        report = XLATE[code] | {release_flag, 7'b0};
    end
endmodule

// File: rtl/kq_store.sv
module kq_store #(
    parameter int DEPTH = 256,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr0_v,
    input  logic [7:0]       wr0_d,
    input  logic             wr1_v,
    input  logic [7:0]       wr1_d,
    input  logic             rd,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] level,
    output logic             rx_pulse
);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr, wptr_b;
    logic             acc0, acc1, take;
    logic [CNT_W-1:0] level_nx;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        acc0     = wr0_v && (level < CAP);
        acc1     = wr1_v && ((level + CNT_W'(acc0)) < CAP);
        take     = rd && (level != '0);
        wptr_b   = acc0 ? bump(wptr) : wptr;
        level_nx = level + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(take);
        rd_data  = (level == '0) ? 8'h00 : mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (acc0) mem[wptr]   <= wr0_d;
        if (acc1) mem[wptr_b] <= wr1_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            level    <= '0;
            rx_pulse <= 1'b0;
        end else begin
            wptr     <= acc1 ? bump(wptr_b) : wptr_b;
            if (take) rptr <= bump(rptr);
            level    <= level_nx;
            rx_pulse <= acc0 || acc1 || (take && (level_nx != '0));
        end
    end
endmodule

// File: rtl/kbd_reply_queue.sv
module kbd_reply_queue #(
    parameter int DEPTH = 256,
    parameter kq_pkg::xlate_t XLATE = kq_pkg::default_xlate()
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_valid,
    input  logic [6:0] key_code,
    input  logic       key_release,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       pop,
    output logic [7:0] pop_data,
    output logic       has_data,
    output logic       rx_strobe
);
    import kq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    kq_state_e        state_q, state_d;
    logic [7:0]       held_q, held_d;
    logic             reply_hit;
    logic [7:0]       reply_b0, reply_b1, key_byte;
    logic             push0_v, push1_v;
    logic [7:0]       push0_d, push1_d;
    logic [CNT_W-1:0] level;

    kq_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .reply_hit (reply_hit),
        .reply_b0  (reply_b0),
        .reply_b1  (reply_b1)
    );

    kq_key_xlate #(.XLATE(XLATE)) u_xl (
        .code         (key_code),
        .release_flag (key_release),
        .report       (key_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= 8'h00;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        held_d  = held_q;
        push0_v = 1'b0;
        push0_d = 8'h00;
        push1_v = 1'b0;
        push1_d = 8'h00;
        unique case (state_q)
            ST_IDLE: begin
                if (reply_hit) begin
                    push0_v = 1'b1;
                    push0_d = reply_b0;
                    push1_v = 1'b1;
                    push1_d = reply_b1;
                    if (key_valid) begin
                        held_d  = key_byte;
                        state_d = ST_HOLD;
                    end
                end else if (key_valid) begin
                    push0_v = 1'b1;
                    push0_d = key_byte;
                end
            end
            ST_HOLD: begin
                push0_v = 1'b1;
                push0_d = held_q;
                push1_v = key_valid;
                push1_d = key_byte;
            end
            default: ;
        endcase
    end

    kq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr0_v    (push0_v),
        .wr0_d    (push0_d),
        .wr1_v    (push1_v),
        .wr1_d    (push1_d),
        .rd       (pop),
        .rd_data  (pop_data),
        .level    (level),
        .rx_pulse (rx_strobe)
    );

    assign has_data = (level != '0);
endmodule

// File: rtl/kq_checker.sv
module kq_checker #(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pop,
    input logic [7:0]       pop_data,
    input logic             has_data,
    input logic             rx_strobe,
    input logic [CNT_W-1:0] level,
    input logic             in_hold,
    input logic             reply_hit,
    input logic             key_valid,
    input logic             push0_v,
    input logic             push1_v
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CAP);

    // R4
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !has_data) |-> (pop_data == 8'h00));

    // R6
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push0_v && level < CAP) |=> (has_data && rx_strobe));

    // R7
    strobe_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> has_data);

    // R12
    push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push0_v && !push1_v && pop && has_data && level < CAP) |=> $stable(level));

    // R10
    enter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hold && reply_hit && key_valid) |=> in_hold);

    // R11
    leave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |=> !in_hold);
endmodule

bind kbd_reply_queue kq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (pop),
    .pop_data  (pop_data),
    .has_data  (has_data),
    .rx_strobe (rx_strobe),
    .level     (level),
    .in_hold   (state_q == kq_pkg::ST_HOLD),
    .reply_hit (reply_hit),
    .key_valid (key_valid),
    .push0_v   (push0_v),
    .push1_v   (push1_v)
);

// File: tb/tb_kbd_reply_queue.sv
`timescale 1ns/1ps
module tb_kbd_reply_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [6:0] key_code = '0;
    logic       key_release = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       has_data;
    logic       rx_strobe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    kbd_reply_queue dut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .key_release(key_release), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .pop(pop), .pop_data(pop_data), .has_data(has_data), .rx_strobe(rx_strobe)
    );

    function automatic logic [7:0] xl(input int c, input bit r);
        return 8'(((c * 37 + 11) % 128) + (r ? 128 : 0));
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        key_valid = 1'b0; cmd_valid = 1'b0; pop = 1'b0;
    endtask

    task automatic edge_step();
        @(posedge clk); #1;
    endtask

    task automatic send_key(input int c, input bit r);
        key_valid = 1'b1; key_code = 7'(c); key_release = r;
        edge_step(); idle_in();
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_valid = 1'b1; cmd_byte = b;
        edge_step(); idle_in();
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string req);
        pop = 1'b1; #1;
        chk(pop_data, exp, req);
        @(posedge clk); #1; pop = 1'b0;
    endtask

    task automatic t_reset();
        chk({7'b0, has_data}, 8'h00, "R1 has_data");
        chk({7'b0, rx_strobe}, 8'h00, "R1 rx_strobe");
        chk(pop_data, 8'h00, "R1 pop_data");
    endtask

    task automatic t_keys();
        send_key(0, 1'b0);
        chk({7'b0, rx_strobe}, 8'h01, "R6 strobe after push");
        send_key(100, 1'b1);
        send_key(127, 1'b0);
        edge_step();
        chk({7'b0, rx_strobe}, 8'h00, "R6 strobe one cycle");
        pop_expect(xl(0, 0), "R2 R3 key0");
        pop_expect(xl(100, 1), "R2 R3 key100 release");
        pop_expect(xl(127, 0), "R3 key127");
        pop_expect(8'h00, "R4 empty pop");
        chk({7'b0, has_data}, 8'h00, "R4 still empty");
    endtask

    task automatic t_cmds();
        send_cmd(8'h01);
        send_cmd(8'h03);
        send_cmd(8'h07);
        send_cmd(8'h00);
        pop_expect(8'hFF, "R8 first");
        pop_expect(8'h05, "R8 second");
        pop_expect(8'hFE, "R9 first");
        pop_expect(8'h20, "R9 second");
        chk({7'b0, has_data}, 8'h00, "R9 others ignored");
    endtask

    task automatic t_collide();
        cmd_valid = 1'b1; cmd_byte = 8'h01;
        key_valid = 1'b1; key_code = 7'd9; key_release = 1'b0;
        edge_step();
        cmd_byte = 8'h07; key_code = 7'd44; key_release = 1'b1;
        edge_step(); idle_in();
        edge_step();
        pop_expect(8'hFF, "R10 reply first");
        pop_expect(8'h05, "R10 reply second");
        pop_expect(xl(9, 0), "R10 held key");
        pop_expect(xl(44, 1), "R11 key in hold");
        chk({7'b0, has_data}, 8'h00, "R11 cmd in hold ignored");
    endtask

    task automatic t_push_pop();
        send_key(5, 1'b0);
        key_valid = 1'b1; key_code = 7'd6; key_release = 1'b0; pop = 1'b1; #1;
        chk(pop_data, xl(5, 0), "R12 pop old");
        edge_step(); idle_in();
        chk({7'b0, has_data}, 8'h01, "R12 level kept");
        pop_expect(xl(6, 0), "R12 new byte");
        chk({7'b0, has_data}, 8'h00, "R12 drained");
    endtask

    task automatic t_resignal();
        send_key(1, 1'b0);
        send_key(2, 1'b0);
        pop_expect(xl(1, 0), "R7 first");
        chk({7'b0, rx_strobe}, 8'h01, "R7 resignal");
        pop_expect(xl(2, 0), "R7 last");
        chk({7'b0, rx_strobe}, 8'h00, "R7 no signal when empty");
    endtask

    task automatic t_full();
        for (int i = 0; i < 256; i++) begin
            key_valid = 1'b1; key_code = 7'(i % 128); key_release = (i >= 128);
            edge_step();
        end
        key_code = 7'd3; key_release = 1'b0; pop = 1'b1; #1;
        chk(pop_data, xl(0, 0), "R5 pop while full");
        edge_step(); idle_in();
        for (int i = 1; i < 256; i++) begin
            pop_expect(xl(i % 128, i >= 128), "R5 drain order");
        end
        chk({7'b0, has_data}, 8'h00, "R5 extra push dropped");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_keys();
        t_cmds();
        t_collide();
        t_push_pop();
        t_resignal();
        t_full();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule